// File: doc/BRIEF.md
# Multiplexed DRAM Cycle Sequencer

This block runs local-memory bus cycles for a processor. Each clock of `clk` is one quarter-period of the processor cycle, so every segment of a memory access takes the four quarters Q1, Q2, Q3 and Q4. An access first runs an address segment. In that segment the block drives the row address on a multiplexed row/column bus and drives the full address, with a 4-bit status code in its low bits, on the shared address/data bus. It then pulls the address latch strobe and RAS low. After that it runs one data segment for a read or a write, or two data segments (read, then write) for a read-modify-write. RAS stays low across both data segments.

In every data segment the block presents the column address. It samples a ready input and a page-mode input at the end of each Q2 quarter, and it repeats Q2 as a wait state while ready is low. It pulses CAS in Q3 and steers the external data buffers with two active-low direction strobes. A stretch enable, sampled when the request is accepted, adds one extra Q4 quarter to the address segment and to the read segment of a read-modify-write. This doubles the time the row address stays valid after RAS falls.

Top module: `dram_cycle_seq`

## Requirements
- R1: A request (`req_i` high while `busy_o` is low at a rising edge) starts the address segment on the next clock. Kind encoding: 0 = read, 1 = write, 2 = read-modify-write, 3 = read. During the address segment, `rca_o` = address bits [27:15] (row), `ad_o` = {address[31:4], status}, and `ad_oe_o` = 1.
- R2: `alatch_n_o` is low in address Q3 and Q4 and high otherwise. RAS falls at the start of address Q4. Row and address are still driven during that Q4.
- R3: In address Q4, `ddout_n_o` goes high for read and read-modify-write and stays low for write. It is low in address Q1–Q3 and in write segments, and high elsewhere.
- R4: In data segments, `rca_o` = address bits [14:2] (column). A write segment drives `ad_o` = write data with `ad_oe_o` = 1. A read segment sets `ad_oe_o` = 0 and `ad_o` = 0, and drives `ddin_n_o` low in Q2–Q4.
- R5: `rdy_i` is sampled at the end of every data-segment Q2. Low repeats Q2 as a wait state with all outputs unchanged.
- R6: `page_ok_o` takes the inverse of `page_n_i` at the end of every data-segment Q2. It is 0 after reset.
- R7: In a write segment, `we_n_o` is low in Q1–Q3 and `cas_n_o` is low only in Q3. Both are high in Q4 while the data is still driven. A read segment pulses `cas_n_o` low in Q3 only.
- R8: `rdata_o` captures `rd_data_i` at the end of read-segment Q3.
- R9: With the stretch enable high at acceptance, address Q4 lasts two clocks with all outputs held. The row then stays valid for two quarters after RAS falls instead of one.
- R10: The read segment of a read-modify-write is stretched the same way. A write segment and a plain read segment are never stretched.
- R11: RAS stays low from address Q4 through the final Q4 of the access, including between the two segments of a read-modify-write. It is high when idle, and CAS is low only while RAS is low.
- R12: `busy_o` is high from the first address quarter through the final Q4. `done_o` is high only in that final Q4. A request while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start an access |
| req_kind_i | input | 2 | Access kind |
| req_addr_i | input | 32 | Access address |
| req_stat_i | input | 4 | Bus-status code |
| req_wdata_i | input | 32 | Write data |
| stretch_en_i | input | 1 | Configuration stretch enable |
| page_n_i | input | 1 | Page-mode indication, active low |
| rdy_i | input | 1 | Memory ready |
| rd_data_i | input | 32 | Data returned by memory |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Final quarter of the access |
| page_ok_o | output | 1 | Last sampled page-mode support |
| rdata_o | output | 32 | Captured read data |
| ad_o | output | 32 | Address/data bus value |
| ad_oe_o | output | 1 | Address/data bus drive enable |
| rca_o | output | 13 | Row/column address |
| ras_n_o | output | 1 | Row strobe |
| cas_n_o | output | 1 | Column strobe |
| we_n_o | output | 1 | Write enable |
| alatch_n_o | output | 1 | Address latch strobe |
| ddout_n_o | output | 1 | Outbound buffer strobe |
| ddin_n_o | output | 1 | Inbound buffer strobe |

## Verification
Wait-state insertion and the stretch quarter can both act in the same read-modify-write. The read segment may hold in Q2 for several clocks and then take an extra Q4 before the write segment starts. The bench provokes this with read-modify-write accesses that have stretch enabled and waits in one or both data segments. It judges the result by comparing every quarter's strobe levels and bus contents against an expected trace, built from these rules, in which the repeated Q2 items come before the doubled Q4 item.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
   typedef enum logic [1:0] {SEG_IDLE, SEG_ADDR, SEG_RDAT, SEG_WDAT} seg_e;
   typedef enum logic [1:0] {PH_Q1, PH_Q2, PH_Q3, PH_Q4} ph_e;
   typedef enum logic [1:0] {K_RD = 2'd0, K_WR = 2'd1, K_RMW = 2'd2, K_RDX = 2'd3} kind_e;

   function automatic seg_e seg_after(input seg_e s, input kind_e k);
      case (s)
         SEG_ADDR: seg_after = (k == K_WR) ? SEG_WDAT : SEG_RDAT;
         SEG_RDAT: seg_after = (k == K_RMW) ? SEG_WDAT : SEG_IDLE;
         default:  seg_after = SEG_IDLE;
      endcase
   endfunction
endpackage

// File: rtl/dcs_phase_ctrl.sv
module dcs_phase_ctrl
   import dcs_pkg::*;
#(
   parameter bit HAS_STRETCH = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  req,
   input  kind_e kind,
   input  logic  stretch_en,
   input  logic  rdy,
   input  logic  page_n,
   output seg_e  seg,
   output ph_e   ph,
   output logic  xq,
   output kind_e kind_q,
   output logic  accept,
   output logic  last,
   output logic  page_ok
);
   logic st_q;
   logic stretchable;
   logic hold_x;
   logic in_data;
   seg_e nxt;

   generate
      if (HAS_STRETCH) begin : g_stretch
         assign stretchable = st_q && ((seg == SEG_ADDR) ||
                                       (seg == SEG_RDAT && kind_q == K_RMW));
      end else begin : g_plain
         assign stretchable = 1'b0;
      end
   endgenerate

   assign accept  = (seg == SEG_IDLE) && req;
   assign in_data = (seg == SEG_RDAT) || (seg == SEG_WDAT);
   assign hold_x  = (ph == PH_Q4) && stretchable && !xq;
   assign nxt     = seg_after(seg, kind_q);
   assign last    = (seg != SEG_IDLE) && (ph == PH_Q4) && !hold_x && (nxt == SEG_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg     <= SEG_IDLE;
         ph      <= PH_Q1;
         xq      <= 1'b0;
         st_q    <= 1'b0;
         kind_q  <= K_RD;
         page_ok <= 1'b0;
      end else if (accept) begin
         seg    <= SEG_ADDR;
         ph     <= PH_Q1;
         xq     <= 1'b0;
         kind_q <= kind;
         st_q   <= stretch_en;
      end else if (seg != SEG_IDLE) begin
         case (ph)
            PH_Q1: ph <= PH_Q2;
            PH_Q2: begin
               if (!(in_data && !rdy)) ph <= PH_Q3;
               if (in_data) page_ok <= !page_n;
            end
            PH_Q3: ph <= PH_Q4;
            default: begin
               if (hold_x) begin
                  xq <= 1'b1;
               end else begin
                  xq  <= 1'b0;
                  ph  <= PH_Q1;
                  seg <= nxt;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/dcs_strobe_dec.sv
module dcs_strobe_dec
   import dcs_pkg::*;
(
   input  seg_e  seg,
   input  ph_e   ph,
   input  kind_e kind_q,
   output logic  ras_n,
   output logic  cas_n,
   output logic  we_n,
   output logic  alatch_n,
   output logic  ddout_n,
   output logic  ddin_n
);
   logic in_data;
   assign in_data = (seg == SEG_RDAT) || (seg == SEG_WDAT);

   always_comb begin
      ras_n    = !(((seg == SEG_ADDR) && (ph == PH_Q4)) || in_data);
      alatch_n = !((seg == SEG_ADDR) && ((ph == PH_Q3) || (ph == PH_Q4)));
      cas_n    = !(in_data && (ph == PH_Q3));
      we_n     = !((seg == SEG_WDAT) && (ph != PH_Q4));
      ddin_n   = !((seg == SEG_RDAT) && (ph != PH_Q1));
      case (seg)
         SEG_ADDR: ddout_n = (ph == PH_Q4) ? (kind_q != K_WR) : 1'b0;
         SEG_WDAT: ddout_n = 1'b0;
         default:  ddout_n = 1'b1;
      endcase
   end
endmodule

// File: rtl/dcs_bus_path.sv
module dcs_bus_path
   import dcs_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int STAT_W  = 4,
   parameter int RCA_W   = 13,
   parameter int COL_LSB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  seg_e              seg,
   input  ph_e               ph,
   input  logic [BUS_W-1:0]  addr,
   input  logic [STAT_W-1:0] stat,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [BUS_W-1:0]  rd_data,
   output logic [BUS_W-1:0]  ad,
   output logic              ad_oe,
   output logic [RCA_W-1:0]  rca,
   output logic [BUS_W-1:0]  rdata
);
   localparam int ROW_LSB = COL_LSB + RCA_W;
   localparam int LOW_W   = (COL_LSB < STAT_W) ? COL_LSB : STAT_W;

   logic [BUS_W-1:0]  addr_q;
   logic [STAT_W-1:0] stat_q;
   logic [BUS_W-1:0]  wdata_q;

   generate
      if (LOW_W > 0) begin : g_lowbits
         logic unused_low;
         assign unused_low = ^addr_q[LOW_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         stat_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
      end else begin
         if (accept) begin
            addr_q  <= addr;
            stat_q  <= stat;
            wdata_q <= wdata;
         end
         if (seg == SEG_RDAT && ph == PH_Q3) rdata <= rd_data;
      end
   end

   always_comb begin
      ad    = '0;
      ad_oe = 1'b0;
      rca   = '0;
      case (seg)
         SEG_ADDR: begin
            ad    = {addr_q[BUS_W-1:STAT_W], stat_q};
            ad_oe = 1'b1;
            rca   = addr_q[ROW_LSB +: RCA_W];
         end
         SEG_WDAT: begin
            ad    = wdata_q;
            ad_oe = 1'b1;
            rca   = addr_q[COL_LSB +: RCA_W];
         end
         SEG_RDAT: rca = addr_q[COL_LSB +: RCA_W];
         default: ;
      endcase
   end
endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
   import dcs_pkg::*;
#(
   parameter int BUS_W       = 32,
   parameter int STAT_W      = 4,
   parameter int RCA_W       = 13,
   parameter int COL_LSB     = 2,
   parameter bit HAS_STRETCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [1:0]        req_kind_i,
   input  logic [BUS_W-1:0]  req_addr_i,
   input  logic [STAT_W-1:0] req_stat_i,
   input  logic [BUS_W-1:0]  req_wdata_i,
   input  logic              stretch_en_i,
   input  logic              page_n_i,
   input  logic              rdy_i,
   input  logic [BUS_W-1:0]  rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              page_ok_o,
   output logic [BUS_W-1:0]  rdata_o,
   output logic [BUS_W-1:0]  ad_o,
   output logic              ad_oe_o,
   output logic [RCA_W-1:0]  rca_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic              alatch_n_o,
   output logic              ddout_n_o,
   output logic              ddin_n_o
);
   localparam int ROW_LSB = COL_LSB + RCA_W;

   if (ROW_LSB + RCA_W > BUS_W) begin : g_bad_row
      $error("row field does not fit the bus width");
   end
   if (STAT_W < 1 || STAT_W >= BUS_W) begin : g_bad_stat
      $error("status width out of range");
   end

   seg_e  seg;
   ph_e   ph;
   kind_e kind_q;
   logic  xq;
   logic  accept;
   logic  last;

   dcs_phase_ctrl #(.HAS_STRETCH(HAS_STRETCH)) u_phase (
      .clk(clk), .rst_n(rst_n), .req(req_i), .kind(kind_e'(req_kind_i)),
      .stretch_en(stretch_en_i), .rdy(rdy_i), .page_n(page_n_i),
      .seg(seg), .ph(ph), .xq(xq), .kind_q(kind_q), .accept(accept),
      .last(last), .page_ok(page_ok_o)
   );

   dcs_strobe_dec u_strobe (
      .seg(seg), .ph(ph), .kind_q(kind_q),
      .ras_n(ras_n_o), .cas_n(cas_n_o), .we_n(we_n_o),
      .alatch_n(alatch_n_o), .ddout_n(ddout_n_o), .ddin_n(ddin_n_o)
   );

   dcs_bus_path #(.BUS_W(BUS_W), .STAT_W(STAT_W), .RCA_W(RCA_W), .COL_LSB(COL_LSB)) u_bus (
      .clk(clk), .rst_n(rst_n), .accept(accept), .seg(seg), .ph(ph),
      .addr(req_addr_i), .stat(req_stat_i), .wdata(req_wdata_i), .rd_data(rd_data_i),
      .ad(ad_o), .ad_oe(ad_oe_o), .rca(rca_o), .rdata(rdata_o)
   );

   assign busy_o = (seg != SEG_IDLE);
   assign done_o = last;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker
   import dcs_pkg::*;
#(
   parameter int BUS_W = 32,
   parameter int RCA_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rdy,
   input logic             busy,
   input logic             done,
   input seg_e             seg,
   input ph_e              ph,
   input logic             xq,
   input logic             ras_n,
   input logic             cas_n,
   input logic             we_n,
   input logic             ad_oe,
   input logic [RCA_W-1:0] rca,
   input logic [BUS_W-1:0] ad
);
   assert_cas_in_ras_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   assert_we_with_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> ad_oe);

   assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (seg == SEG_RDAT || seg == SEG_WDAT) && ph == PH_Q2 && !rdy)
      |=> (ph == PH_Q2 && $stable(rca) && $stable(ad) && $stable(cas_n) && $stable(we_n)));

   assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> ($stable(rca) && $stable(ad)));

   assert_stretch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_Q4 && xq) |-> (!ras_n && $past(ph) == PH_Q4 && $stable(rca) && $stable(ad)));

   assert_done_ends_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

bind dram_cycle_seq dcs_checker #(.BUS_W(BUS_W), .RCA_W(RCA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rdy(rdy_i), .busy(busy_o), .done(done_o),
   .seg(seg), .ph(ph), .xq(xq), .ras_n(ras_n_o), .cas_n(cas_n_o),
   .we_n(we_n_o), .ad_oe(ad_oe_o), .rca(rca_o), .ad(ad_o)
);

// File: tb/tb_dram_cycle_seq.sv
module tb_dram_cycle_seq;
   typedef struct packed {
      logic        ras, cas, we, al, ddo, ddi, oe, done, rdy, pgchk;
      logic [31:0] ad;
      logic [12:0] rca;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, sten = 1'b0, page_n = 1'b1, rdy = 1'b1;
   logic [1:0] kind = 2'd0;
   logic [31:0] addr = '0, wdata = '0, rd_data = '0;
   logic [3:0] stat = '0;
   logic busy, done, page_ok, ad_oe, ras_n, cas_n, we_n, alatch_n, ddout_n, ddin_n;
   logic [31:0] rdata, ad;
   logic [12:0] rca;

   item_t q[$];
   int    n_chk = 0, n_fail = 0;
   bit    finished = 0;
   bit    exp_pg = 0;
   string cur_tag = "reset";

   always #5 clk = ~clk;

   dram_cycle_seq dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_kind_i(kind), .req_addr_i(addr),
      .req_stat_i(stat), .req_wdata_i(wdata), .stretch_en_i(sten), .page_n_i(page_n),
      .rdy_i(rdy), .rd_data_i(rd_data), .busy_o(busy), .done_o(done),
      .page_ok_o(page_ok), .rdata_o(rdata), .ad_o(ad), .ad_oe_o(ad_oe), .rca_o(rca),
      .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .alatch_n_o(alatch_n),
      .ddout_n_o(ddout_n), .ddin_n_o(ddin_n)
   );

   task automatic chk(input bit ok, input string r, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s [%s]: got %h expected %h", r, what, cur_tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // monitor: pops one expected quarter per busy clock
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (busy) begin
            if (q.size() == 0) begin
               chk(0, "R12", "busy beyond expected end", 32'(busy), 0);
            end else begin
               item_t it;
               it = q.pop_front();
               chk(ras_n == it.ras, "R11", "ras_n", 32'(ras_n), 32'(it.ras));
               chk(cas_n == it.cas, "R7", "cas_n", 32'(cas_n), 32'(it.cas));
               chk(we_n == it.we, "R7", "we_n", 32'(we_n), 32'(it.we));
               chk(alatch_n == it.al, "R2", "alatch_n", 32'(alatch_n), 32'(it.al));
               chk(ddout_n == it.ddo, "R3", "ddout_n", 32'(ddout_n), 32'(it.ddo));
               chk(ddin_n == it.ddi, "R4", "ddin_n", 32'(ddin_n), 32'(it.ddi));
               chk(ad_oe == it.oe, "R4", "ad_oe", 32'(ad_oe), 32'(it.oe));
               chk(ad == it.ad, "R1", "ad", ad, it.ad);
               chk(rca == it.rca, "R1", "rca", 32'(rca), 32'(it.rca));
               chk(done == it.done, "R12", "done", 32'(done), 32'(it.done));
               if (it.pgchk) chk(page_ok == exp_pg, "R6", "page_ok", 32'(page_ok), 32'(exp_pg));
               rdy = it.rdy;
            end
         end else begin
            rdy = 1'b1;
         end
      end
   end

   task automatic data_seg(inout item_t it, input bit wr, input int waits,
                           input bit fin, input bit stretch, input logic [31:0] wd);
      it.al = 1; it.ddi = 1; it.cas = 1; it.done = 0;
      it.ddo = wr ? 1'b0 : 1'b1;
      it.oe = wr; it.ad = wr ? wd : 32'h0; it.we = wr ? 1'b0 : 1'b1;
      q.push_back(it);                      // Q1
      it.ddi = wr;
      for (int i = 0; i < waits; i++) begin
         it.rdy = 0; q.push_back(it);       // R5 wait states
      end
      it.rdy = 1; q.push_back(it);          // Q2
      it.pgchk = 1; it.cas = 0; q.push_back(it); // Q3
      it.cas = 1; it.we = 1; it.done = fin;
      q.push_back(it);                      // Q4
      if (stretch) q.push_back(it);         // R10 stretched read Q4
   endtask

   task automatic run(input logic [1:0] k, input logic [31:0] a, input logic [3:0] s,
                      input logic [31:0] wd, input logic [31:0] rv, input bit se,
                      input int w1, input int w2, input bit pg, input bit poke,
                      input string tag);
      item_t it;
      bit is_wr  = (k == 2'd1);
      bit is_rmw = (k == 2'd2);
      @(negedge clk);
      cur_tag = tag;
      it = '0;
      it.ras = 1; it.cas = 1; it.we = 1; it.al = 1; it.ddo = 0; it.ddi = 1;
      it.oe = 1; it.rdy = 1; it.ad = {a[31:4], s}; it.rca = a[27:15];
      q.push_back(it); q.push_back(it);     // Q1, Q2
      it.al = 0; q.push_back(it);           // Q3
      it.ras = 0; it.ddo = !is_wr;
      q.push_back(it);                      // Q4
      if (se) q.push_back(it);              // R9 stretch quarter
      it.rca = a[14:2];
      if (is_wr) begin
         data_seg(it, 1, w1, 1, 0, wd);
      end else if (is_rmw) begin
         data_seg(it, 0, w1, 0, se, wd);
         data_seg(it, 1, w2, 1, 0, wd);
      end else begin
         data_seg(it, 0, w1, 1, 0, wd);
      end
      req = 1; kind = k; addr = a; stat = s; wdata = wd; rd_data = rv;
      sten = se; page_n = pg;
      @(negedge clk);
      exp_pg = !pg;
      if (poke) begin                       // R12 request while busy
         addr = ~a; kind = 2'd1; stat = ~s; wdata = ~wd; sten = !se;
         @(negedge clk);
      end
      req = 0;
      wait (q.size() == 0);
      @(negedge clk);
      chk(busy == 1'b0, "R12", "busy after final quarter", 32'(busy), 0);
      chk(ras_n == 1'b1, "R11", "ras_n idle", 32'(ras_n), 1);
      if (!is_wr) chk(rdata == rv, "R8", "rdata", rdata, rv);
      chk(page_ok == !pg, "R6", "page_ok held", 32'(page_ok), 32'(!pg));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0, "R12", "reset busy", 32'(busy), 0);
      chk(ras_n == 1 && cas_n == 1 && we_n == 1, "R11", "reset strobes",
          {29'd0, ras_n, cas_n, we_n}, 32'd7);
      chk(ad_oe == 0, "R4", "reset ad_oe", 32'(ad_oe), 0);
      chk(page_ok == 0, "R6", "reset page_ok", 32'(page_ok), 0);
      rst_n = 1'b1;
      run(2'd0, 32'h1234_5678, 4'hA, 32'h0, 32'hCAFE_0001, 0, 0, 0, 1, 0, "read plain R1");
      run(2'd1, 32'hF0E1_D2C3, 4'h5, 32'hDEAD_BEEF, 32'h0, 0, 2, 0, 0, 0, "write waits R5");
      run(2'd0, 32'h0BAD_F00D, 4'h3, 32'h0, 32'h1357_9BDF, 1, 3, 0, 0, 0, "read stretch R9");
      run(2'd2, 32'h7654_3210, 4'hC, 32'hA5A5_5A5A, 32'h2468_ACE0, 0, 1, 0, 1, 0, "rmw plain R11");
      run(2'd2, 32'h89AB_CDEF, 4'h9, 32'h0F0F_F0F0, 32'h1111_2222, 1, 2, 3, 0, 0, "rmw stretch R10");
      run(2'd1, 32'h5555_AAAA, 4'h6, 32'h3C3C_C3C3, 32'h0, 1, 0, 1, 1, 1, "write stretch ignored req R12");
      run(2'd3, 32'hFFFF_0004, 4'hF, 32'h0, 32'h7777_8888, 0, 0, 0, 0, 0, "kind3 read R1");
      run(2'd2, 32'h0000_0000, 4'h0, 32'hFFFF_FFFF, 32'h9999_0000, 1, 0, 0, 1, 0, "rmw stretch nowait R10");
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL R12 watchdog expired [%s]: got %h expected %h", cur_tag, 0, 1);
         summary();
         $finish;
      end
   end
endmodule